// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the slave side of a parallel host port. An external microcontroller uses it to read and write a small register bank through a 10-bit address and an 8-bit data path. A static mode input selects between two bus families.

- **Mode 0** is a direction-line bus. The write pin gives the transfer direction, the read pin is ignored, and the handshake and interrupt are both active low.
- **Mode 1** is a dual-strobe bus. There are separate active-low read and write strobes, and the handshake (ready) and interrupt are both active high.

The host bus is assumed to be synchronous to `clk`. The bidirectional data bus is presented as separate `data_i` and `data_o` vectors plus an output enable, so that the pad can build the tri-state driver. The host interface has no valid/ready stream and no back-pressure. Each access is a single transfer, paced only by chip select and the handshake.

Behind the port sit four registers:

| Address | Register | Access |
|---|---|---|
| 0x000 | interrupt status (8 bits) | write-1-to-clear |
| 0x001 | interrupt mask (8 bits) | read/write |
| 0x002 | low-power flag (bit 0) | read/write |
| 0x003 | scratch (8 bits) | read/write |

Each status bit is set by a pulse on the matching bit of `evt_i`. The interrupt pin reports any bit that is both pending and enabled. A wake-up pin pulses when an enabled source becomes pending while the low-power flag is set.

Top module: `hostport_dual`

## Requirements
- R1: In mode 0, with `cs_n` low, `wr_n`=0 requests a write and `wr_n`=1 requests a read; the value of `rd_n` has no effect.
- R2: In mode 1, `wr_n`=0 requests a write (taking priority if both strobes are low), `rd_n`=0 with `wr_n`=1 requests a read, and with both strobes high no access starts even while `cs_n` is low.
- R3: An access starts on the first clock edge that sees `cs_n` low with a read or write request. The handshake becomes active after that edge and stays active until the first edge that sees `cs_n` high. The handshake is active low in mode 0 and active high in mode 1.
- R4: `data_oe` is 1 only while `cs_n` is low and a read is requested; otherwise it is 0 and `data_o` is 0.
- R5: Reads return the current register contents: status at 0x000, mask at 0x001, the low-power flag in bit 0 of 0x002 (upper bits 0), and the scratch value at 0x003. Writes to 0x001, 0x002 and 0x003 store `data_i`.
- R6: The full 10-bit address is decoded. Any other address, such as 0x101, reads as 0, and a write to it changes no register.
- R7: `evt_i[k]`=1 at a clock edge sets status bit k. A write to 0x000 clears each status bit whose `data_i` bit is 1. A set and a clear in the same cycle leave the bit set.
- R8: The interrupt is active when any status bit is 1 while its mask bit is 1. The interrupt pin is active low in mode 0 and active high in mode 1.
- R9: `wake_pin` is 1 for the clock after an edge at which the low-power flag was 1 and some bit k had `evt_i[k]`=1, mask bit 1 and status bit 0. Otherwise it is 0.
- R10: After reset all registers are 0, `data_oe` is 0, and the handshake and interrupt pins show their inactive level for the selected mode.
- R11: An access writes at most once: holding `cs_n` and the write request while `data_i` changes does not store the later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Bus family: 0 direction-line, 1 dual-strobe (static) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe (mode 1), ignored in mode 0 |
| wr_n | input | 1 | Write strobe (mode 1) or direction, 0 = write (mode 0) |
| addr | input | 10 | Register address |
| data_i | input | 8 | Write data from the host bus |
| data_o | output | 8 | Read data toward the host bus |
| data_oe | output | 1 | Drive enable for the data pads |
| evt_i | input | 8 | Interrupt source pulses, one per status bit |
| ack_pin | output | 1 | Handshake: acknowledge (mode 0) or ready (mode 1) |
| irq_pin | output | 1 | Interrupt request, polarity per mode |
| wake_pin | output | 1 | One-clock wake-up pulse |

## Verification
The bench targets the following corner cases:

- **Mode 0 read pin.** The bench toggles the read pin during mode 0 writes. A design that decoded it in mode 0 would turn those writes into reads or drop them.
- **Idle strobes in mode 1.** The bench holds chip select low with both strobes high in mode 1. A design that started an access there would raise ready with no request.
- **Event against clear.** The bench holds an event active across a write-1-to-clear. A design that let the clear win would lose a pending interrupt.
- **Wake-up qualification.** The bench raises events that are masked, and events that arrive while the low-power flag is clear. Each must give no wake-up pulse. A design missing either qualification would wake the host spuriously.
- **Address decode and repeat writes.** Writes go to an alias address that differs only in the upper bits, and write data changes during a held cycle. A design with partial decode or with a level-sensitive write would corrupt a real register.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int HBI_ADDR_W   = 10;
  localparam int HBI_DATA_W   = 8;
  localparam int REG_STATUS   = 'h000;
  localparam int REG_MASK     = 'h001;
  localparam int REG_SLEEP    = 'h002;
  localparam int REG_SCRATCH  = 'h003;
endpackage

// File: rtl/hbi_decode.sv
module hbi_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_stb,
  output logic rd_en,
  output logic ack_pin
);
  logic rd_req, wr_req, start, busy_q;

  // strobe meaning depends on the bus family
  always_comb begin
    wr_req = !wr_n;
    if (mode_sel) rd_req = !rd_n && wr_n;
    else          rd_req = wr_n;
  end

  assign start  = !cs_n && (rd_req || wr_req) && !busy_q;
  assign wr_stb = start && wr_req;
  assign rd_en  = !cs_n && rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_q <= 1'b0;
    else if (cs_n)  busy_q <= 1'b0;
    else if (start) busy_q <= 1'b1;
  end

  assign ack_pin = mode_sel ? busy_q : !busy_q;
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs #(
  parameter int ADDR_W = hbi_pkg::HBI_ADDR_W,
  parameter int DATA_W = hbi_pkg::HBI_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] mask_q,
  output logic              sleep_q,
  output logic [DATA_W-1:0] rdata
);
  import hbi_pkg::*;
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(REG_MASK);
  localparam logic [ADDR_W-1:0] A_SLEEP   = ADDR_W'(REG_SLEEP);
  localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(REG_SCRATCH);

  logic [DATA_W-1:0] scratch_q;

  assign clr_mask = (wr_stb && addr == A_STATUS) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      sleep_q   <= 1'b0;
      scratch_q <= '0;
    end else if (wr_stb) begin
      if (addr == A_MASK)    mask_q    <= wdata;
      if (addr == A_SLEEP)   sleep_q   <= wdata[0];
      if (addr == A_SCRATCH) scratch_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if      (addr == A_STATUS)  rdata = status_q;
    else if (addr == A_MASK)    rdata = mask_q;
    else if (addr == A_SLEEP)   rdata[0] = sleep_q;
    else if (addr == A_SCRATCH) rdata = scratch_q;
  end
endmodule

// File: rtl/hbi_irq.sv
module hbi_irq #(
  parameter int NSRC = hbi_pkg::HBI_DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_sel,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            sleep_i,
  output logic [NSRC-1:0] status_q,
  output logic            irq_pin,
  output logic            wake_pin
);
  logic [NSRC-1:0] fresh;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    // set beats clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status_q[k] <= 1'b0;
      else if (evt_i[k]) status_q[k] <= 1'b1;
      else if (clr_i[k]) status_q[k] <= 1'b0;
    end
    assign fresh[k] = evt_i[k] && mask_i[k] && !status_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_pin <= 1'b0;
    else        wake_pin <= sleep_i && (|fresh);
  end

  logic pending;
  assign pending = |(status_q & mask_i);
  assign irq_pin = mode_sel ? pending : !pending;
endmodule

// File: rtl/hostport_dual.sv
module hostport_dual #(
  parameter int ADDR_W = hbi_pkg::HBI_ADDR_W,
  parameter int DATA_W = hbi_pkg::HBI_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  input  logic [DATA_W-1:0] evt_i,
  output logic              ack_pin,
  output logic              irq_pin,
  output logic              wake_pin
);
  logic              wr_stb, rd_en, sleep_q;
  logic [DATA_W-1:0] status_q, clr_mask, mask_q, rdata;

  hbi_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .wr_stb(wr_stb), .rd_en(rd_en),
    .ack_pin(ack_pin)
  );

  hbi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr),
    .wdata(data_i), .status_q(status_q), .clr_mask(clr_mask),
    .mask_q(mask_q), .sleep_q(sleep_q), .rdata(rdata)
  );

  hbi_irq #(.NSRC(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .evt_i(evt_i),
    .clr_i(clr_mask), .mask_i(mask_q), .sleep_i(sleep_q),
    .status_q(status_q), .irq_pin(irq_pin), .wake_pin(wake_pin)
  );

  assign data_oe = rd_en;
  assign data_o  = rd_en ? rdata : '0;
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sel,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              data_oe,
  input logic [DATA_W-1:0] evt_i,
  input logic              ack_pin,
  input logic              irq_pin,
  input logic              wake_pin,
  input logic [DATA_W-1:0] mask_q,
  input logic              sleep_q
);
  logic rd_ask, wr_ask, ack_on, irq_on;
  assign wr_ask = !wr_n;
  assign rd_ask = mode_sel ? (!rd_n && wr_n) : wr_n;
  assign ack_on = mode_sel ? ack_pin : !ack_pin;
  assign irq_on = mode_sel ? irq_pin : !irq_pin;

  AST_ACK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (rd_ask || wr_ask) && !ack_on) |=> ack_on); // R3
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !ack_on); // R3
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!cs_n && rd_ask)); // R4
  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_on); // R8
  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pin |-> $past(sleep_q)); // R9
  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pin |-> $past(|(evt_i & mask_q))); // R9
endmodule

bind hostport_dual hbi_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
  .rd_n(rd_n), .wr_n(wr_n), .data_oe(data_oe), .evt_i(evt_i),
  .ack_pin(ack_pin), .irq_pin(irq_pin), .wake_pin(wake_pin),
  .mask_q(mask_q), .sleep_q(sleep_q)
);

// File: tb/test_hostport_dual.sv
module test_hostport_dual;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] data_i = '0, evt_i = '0;
  logic [7:0] data_o;
  logic       data_oe, ack_pin, irq_pin, wake_pin;

  int errors = 0, checks = 0, wake_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostport_dual i_hostport_dual (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe), .evt_i(evt_i),
    .ack_pin(ack_pin), .irq_pin(irq_pin), .wake_pin(wake_pin)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_status = 0, m_mask = 0, m_scratch = 0;
  bit m_sleep = 0, m_busy = 0, m_wake = 0;

  function automatic bit is_rd();
    return mode_sel ? (!rd_n && wr_n) : wr_n;
  endfunction

  function automatic logic [7:0] m_read(input logic [9:0] a);
    case (a)
      10'h000: return m_status;
      10'h001: return m_mask;
      10'h002: return {7'd0, m_sleep};
      10'h003: return m_scratch;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_status = 0; m_mask = 0; m_scratch = 0; m_sleep = 0; m_busy = 0; m_wake = 0;
    end else begin
      bit go, wr;
      logic [7:0] clr;
      wr  = !wr_n;
      go  = !cs_n && (is_rd() || wr) && !m_busy;
      clr = (go && wr && addr == 10'h000) ? data_i : 8'h00;
      m_wake = m_sleep && ((evt_i & m_mask & ~m_status) != 0);
      m_status = (m_status & ~clr) | evt_i;
      if (go && wr) begin
        if (addr == 10'h001) m_mask = data_i;
        if (addr == 10'h002) m_sleep = data_i[0];
        if (addr == 10'h003) m_scratch = data_i;
      end
      if (cs_n) m_busy = 0;
      else if (go) m_busy = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit irq_exp, oe_exp;
      irq_exp = (m_status & m_mask) != 0;
      oe_exp  = !cs_n && is_rd();
      check("R3 handshake", ack_pin, mode_sel ? m_busy : !m_busy);
      check("R8 interrupt", irq_pin, mode_sel ? irq_exp : !irq_exp);
      check("R9 wake", wake_pin, m_wake);
      check("R4 output enable", data_oe, oe_exp);
      check("R5 read data", data_o, oe_exp ? m_read(addr) : 8'h00);
      if (wake_pin) wake_cnt++;
    end
  end

  function automatic bit ack_act();
    return mode_sel ? ack_pin : !ack_pin;
  endfunction

  task automatic wait_ack(input string tag);
    bit seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (ack_act()) begin seen = 1; break; end
    end
    check(tag, seen, 1);
  endtask

  task automatic release_bus();
    @(posedge clk); #1;
    cs_n = 1; rd_n = 1; wr_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic host_write(input logic [9:0] a, input logic [7:0] d, input logic rdpin);
    @(posedge clk); #1;
    cs_n = 0; addr = a; data_i = d; wr_n = 0; rd_n = rdpin;
    wait_ack("R3 write handshake");
    release_bus();
  endtask

  task automatic host_read(input logic [9:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    cs_n = 0; addr = a; wr_n = 1; rd_n = mode_sel ? 1'b0 : 1'b1;
    wait_ack("R3 read handshake");
    d = data_o;
    release_bus();
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(posedge clk); #1; evt_i = v;
    @(posedge clk); #1; evt_i = 0;
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic m);
    @(posedge clk); #1;
    rst_n = 0; mode_sel = m;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(posedge clk); #1;
  endtask

  initial begin
    logic [7:0] rd;
    // ---------------- mode 0 ----------------
    do_reset(1'b0);
    @(negedge clk);
    check("R10 ack idle mode0", ack_pin, 1);
    check("R10 irq idle mode0", irq_pin, 1);
    check("R10 oe idle", data_oe, 0);
    host_read(10'h001, rd); check("R10 mask reset", rd, 8'h00);

    host_write(10'h001, 8'h0F, 1'b0);            // R1: rd_n low is ignored
    host_read(10'h001, rd); check("R1 write with rd_n low", rd, 8'h0F);
    host_write(10'h003, 8'hA5, 1'b1);
    host_read(10'h003, rd); check("R5 scratch", rd, 8'hA5);
    host_write(10'h101, 8'hFF, 1'b1);
    host_read(10'h101, rd); check("R6 unmapped reads zero", rd, 8'h00);
    host_read(10'h003, rd); check("R6 alias write ignored", rd, 8'hA5);
    host_read(10'h001, rd); check("R6 mask untouched", rd, 8'h0F);

    // R11: data changes during a held write cycle
    @(posedge clk); #1;
    cs_n = 0; addr = 10'h003; data_i = 8'h5A; wr_n = 0;
    wait_ack("R3 held write");
    data_i = 8'h33;
    repeat (3) @(posedge clk); #1;
    release_bus();
    host_read(10'h003, rd); check("R11 single write", rd, 8'h5A);

    pulse_evt(8'h04);
    @(negedge clk); check("R8 irq active low", irq_pin, 0);
    host_read(10'h000, rd); check("R7 status set", rd, 8'h04);
    @(posedge clk); #1; evt_i = 8'h04;                 // event held over the clear
    host_write(10'h000, 8'h04, 1'b1);
    evt_i = 0;
    host_read(10'h000, rd); check("R7 set wins over clear", rd, 8'h04);
    host_write(10'h000, 8'h04, 1'b1);
    host_read(10'h000, rd); check("R7 write-1-to-clear", rd, 8'h00);
    @(negedge clk); check("R8 irq released", irq_pin, 1);

    host_write(10'h002, 8'h01, 1'b1);
    host_read(10'h002, rd); check("R5 sleep flag", rd, 8'h01);
    wake_cnt = 0;
    pulse_evt(8'h02);
    repeat (2) @(posedge clk);
    check("R9 one wake pulse", wake_cnt, 1);
    pulse_evt(8'h80);                                  // masked source
    repeat (2) @(posedge clk);
    check("R9 masked source no wake", wake_cnt, 1);
    host_write(10'h002, 8'h00, 1'b1);
    pulse_evt(8'h08);
    repeat (2) @(posedge clk);
    check("R9 no wake when awake", wake_cnt, 1);

    // ---------------- mode 1 ----------------
    do_reset(1'b1);
    @(negedge clk);
    check("R10 ack idle mode1", ack_pin, 0);
    check("R10 irq idle mode1", irq_pin, 0);
    @(posedge clk); #1; cs_n = 0; rd_n = 1; wr_n = 1; addr = 10'h001;
    repeat (3) @(negedge clk);
    check("R2 no strobe no ack", ack_pin, 0);
    check("R2 no strobe no drive", data_oe, 0);
    release_bus();
    host_write(10'h001, 8'h01, 1'b1);
    host_read(10'h001, rd); check("R2 strobe write/read", rd, 8'h01);
    pulse_evt(8'h01);
    @(negedge clk); check("R8 irq active high", irq_pin, 1);
    host_read(10'h000, rd); check("R2 status read", rd, 8'h01);
    host_write(10'h003, 8'hC3, 1'b0);                  // both strobes low: write
    host_read(10'h003, rd); check("R2 write priority", rd, 8'hC3);

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule